// File: doc/BRIEF.md
# Four-Plane Latched Raster Logic Unit

This block sits between a byte-wide CPU port and four 8-bit display memory planes. All four planes share one address. A CPU read fetches the byte at that address from every plane at once and stores the four bytes in per-plane latches. The CPU gets back only the byte of the plane it selected.

A CPU write sends one result byte to each plane in the same access. Each result combines the CPU byte with that plane's latch through a selectable logic function, a bit mask and a plane enable mask. The second operand is the latch from the last read, not the current contents of the destination address.

Because of this, a single read followed by many writes can stamp a four-plane pattern across memory. A copy mode writes the latches back unchanged, which moves four bytes per access for block copies.

Top module: `plane_rop_unit`

## Requirements
- R1: After reset all four latches hold zero, `cpu_rvalid` is low and no plane write enable is active.
- R2: A read strobe drives `mem_rd` and `mem_addr` in the same cycle.
  - The cycle after the strobe, `cpu_rvalid` is low.
  - The cycle after that, `cpu_rvalid` pulses high with `cpu_rdata` equal to the byte of the plane named by `cfg_rd_plane`.
  - `cfg_rd_plane` is sampled in the strobe cycle.
  - Plane p occupies `mem_rdata[8p+7:8p]`.
- R3: Every read loads all four latches from `mem_rdata`, whichever plane is returned to the CPU.
- R4: In normal mode (`cfg_copy`=0) each plane computes `cpu_wdata` op latch. The encoding of `cfg_fn` (bits 4:3 of the mode register) is 00 pass CPU data, 01 AND, 10 OR, 11 XOR.
- R5: A result bit is taken from the logic function where `cfg_mask` is 1 and from the latch where it is 0. A zero mask writes the latches unchanged.
- R6: In copy mode (`cfg_copy`=1) each enabled plane receives its latch byte unmodified. `cpu_wdata`, `cfg_fn` and `cfg_mask` have no effect.
- R7: Plane p is written only when bit p of `cfg_plane_en` is set. Disabled planes keep their stored contents.
- R8: Writes never change the latches, so any number of writes after one read all use the same latch values.
- R9: A write is combinational. In the strobe cycle `mem_we`, `mem_wdata` and `mem_addr` are presented together.
- R10: When `cpu_rd` and `cpu_wr` are both high, the read is performed and no plane is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | CPU read strobe, one cycle |
| cpu_wr | input | 1 | CPU write strobe, one cycle |
| cpu_addr | input | AW | CPU address |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Byte returned to the CPU |
| cpu_rvalid | output | 1 | Read data valid pulse |
| cfg_rd_plane | input | 2 | Plane returned on a read |
| cfg_fn | input | 2 | Logic function field |
| cfg_mask | input | 8 | Bit mask, 1 selects the function result |
| cfg_plane_en | input | 4 | Per-plane write enable mask |
| cfg_copy | input | 1 | 1 = latch copy mode, 0 = normal mode |
| mem_addr | output | AW | Shared plane address |
| mem_rd | output | 1 | Plane read request; data expected the next cycle |
| mem_rdata | input | 32 | Four plane bytes returned by memory |
| mem_we | output | 4 | Per-plane write enables |
| mem_wdata | output | 32 | Four plane result bytes |

## Verification
The hardest situation to reach is one where the latches hold four different bytes. A write must then be shown to combine with them and not with the destination contents.

Through the ports, that state exists only after building a distinct per-plane pattern with single-plane writes and then reading it back. The bench does exactly that for several patterns. It sweeps every function, several masks and several data bytes against each latched pattern, always writing to a different address than the one read. It then checks that a copy write still reproduces the original pattern.

// File: rtl/rop_pkg.sv
package rop_pkg;
  localparam int BYTE_W = 8;
  localparam int FN_W   = 2;

  typedef enum logic [FN_W-1:0] {
    FN_PASS = 2'b00,
    FN_AND  = 2'b01,
    FN_OR   = 2'b10,
    FN_XOR  = 2'b11
  } rop_fn_e;

  // CPU byte combined with the plane latch
  function automatic logic [BYTE_W-1:0] rop_combine(
    input rop_fn_e fn, input logic [BYTE_W-1:0] d, input logic [BYTE_W-1:0] l);
    case (fn)
      FN_AND:  return d & l;
      FN_OR:   return d | l;
      FN_XOR:  return d ^ l;
      default: return d;
    endcase
  endfunction

  // mask bit 1 -> function result, 0 -> latch
  function automatic logic [BYTE_W-1:0] rop_merge(
    input logic [BYTE_W-1:0] alu, input logic [BYTE_W-1:0] l,
    input logic [BYTE_W-1:0] mask);
    return (alu & mask) | (l & ~mask);
  endfunction
endpackage

// File: rtl/rop_lane.sv
module rop_lane
  import rop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  rop_fn_e           fn,
  input  logic              copy_mode,
  input  logic [BYTE_W-1:0] cpu_byte,
  input  logic [BYTE_W-1:0] lat,
  input  logic [BYTE_W-1:0] mask,
  output logic [BYTE_W-1:0] result
);
  logic [BYTE_W-1:0] alu_out;

  always_comb begin
    alu_out = rop_combine(fn, cpu_byte, lat);
    result  = copy_mode ? lat : rop_merge(alu_out, lat, mask);
  end

  // R5: a cleared mask leaves every bit to the latch
  a_r5_zero_mask_keeps_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (!copy_mode && mask == '0) |-> (result == lat));

  // R4: pass with full mask delivers the CPU byte
  a_r4_pass_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (!copy_mode && fn == FN_PASS && mask == '1) |-> (result == cpu_byte));

  // R6: copy mode yields the latch whatever the CPU byte is
  a_r6_copy_is_latch: assert property (@(posedge clk) disable iff (!rst_n)
    copy_mode |-> (result == lat));
endmodule

// File: rtl/rop_latch_bank.sv
module rop_latch_bank
  import rop_pkg::*;
#(
  parameter int PLANES = 4,
  localparam int SELW  = $clog2(PLANES),
  localparam int BUS_W = PLANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [SELW-1:0]   sel,
  input  logic [BUS_W-1:0]  plane_bytes,
  output logic [BUS_W-1:0]  lat_flat,
  output logic [BYTE_W-1:0] sel_byte
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_flat <= '0;
      sel_byte <= '0;
    end else if (cap) begin
      lat_flat <= plane_bytes;
      sel_byte <= plane_bytes[sel*BYTE_W +: BYTE_W];
    end
  end

  // R8: latches move only on a capture
  a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(lat_flat));

  // R3: a capture stores all planes
  a_r3_capture_all: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (lat_flat == $past(plane_bytes)));
endmodule

// File: rtl/plane_rop_unit.sv
module plane_rop_unit
  import rop_pkg::*;
#(
  parameter int AW     = 16,
  parameter int PLANES = 4,
  localparam int SELW  = $clog2(PLANES),
  localparam int BUS_W = PLANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic [BYTE_W-1:0] cpu_rdata,
  output logic              cpu_rvalid,
  input  logic [SELW-1:0]   cfg_rd_plane,
  input  logic [FN_W-1:0]   cfg_fn,
  input  logic [BYTE_W-1:0] cfg_mask,
  input  logic [PLANES-1:0] cfg_plane_en,
  input  logic              cfg_copy,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_rd,
  input  logic [BUS_W-1:0]  mem_rdata,
  output logic [PLANES-1:0] mem_we,
  output logic [BUS_W-1:0]  mem_wdata
);
  // named internal events
  logic            rd_go, wr_go, rd_pend, cap_evt;
  logic [SELW-1:0] rd_sel_q;
  logic [BUS_W-1:0] lat_flat;
  rop_fn_e         fn;

  assign rd_go    = cpu_rd;
  assign wr_go    = cpu_wr & ~cpu_rd;
  assign cap_evt  = rd_pend;
  assign fn       = rop_fn_e'(cfg_fn);
  assign mem_addr = cpu_addr;
  assign mem_rd   = rd_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend    <= 1'b0;
      rd_sel_q   <= '0;
      cpu_rvalid <= 1'b0;
    end else begin
      rd_pend    <= rd_go;
      cpu_rvalid <= cap_evt;
      if (rd_go) rd_sel_q <= cfg_rd_plane;
    end
  end

  rop_latch_bank #(.PLANES(PLANES)) u_latches (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap         (cap_evt),
    .sel         (rd_sel_q),
    .plane_bytes (mem_rdata),
    .lat_flat    (lat_flat),
    .sel_byte    (cpu_rdata)
  );

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    rop_lane u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .fn        (fn),
      .copy_mode (cfg_copy),
      .cpu_byte  (cpu_wdata),
      .lat       (lat_flat[p*BYTE_W +: BYTE_W]),
      .mask      (cfg_mask),
      .result    (mem_wdata[p*BYTE_W +: BYTE_W])
    );
    assign mem_we[p] = wr_go & cfg_plane_en[p];
  end

  // R7: never write a disabled plane
  a_r7_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we & ~cfg_plane_en) == '0);

  // R10: a read in the same cycle suppresses the write
  a_r10_read_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd |-> (mem_we == '0));

  // R9: enables appear only in a write strobe cycle
  a_r9_we_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we != '0) |-> cpu_wr);

  // R2: read data valid two cycles after the strobe, not one
  a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd |=> !cpu_rvalid ##1 cpu_rvalid);

  // R1: valid is a single pulse per read
  a_r1_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> !$past(cpu_rvalid) || $past(cpu_rd, 2));
endmodule

// File: tb/test_plane_rop_unit.sv
module test_plane_rop_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_rvalid;
  logic [1:0]  cfg_rd_plane = '0;
  logic [1:0]  cfg_fn = '0;
  logic [7:0]  cfg_mask = 8'hFF;
  logic [3:0]  cfg_plane_en = 4'hF;
  logic        cfg_copy = 1'b0;
  logic [AW-1:0] mem_addr;
  logic        mem_rd;
  logic [31:0] mem_rdata;
  logic [3:0]  mem_we;
  logic [31:0] mem_wdata;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  plane_rop_unit #(.AW(AW)) i_plane_rop_unit (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_rvalid(cpu_rvalid), .cfg_rd_plane(cfg_rd_plane), .cfg_fn(cfg_fn),
    .cfg_mask(cfg_mask), .cfg_plane_en(cfg_plane_en), .cfg_copy(cfg_copy),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_wdata(mem_wdata));

  // bench memory: four planes, synchronous read
  logic [31:0] mem [16];
  logic [31:0] rq = '0;
  assign mem_rdata = rq;
  always @(posedge clk) begin
    if (mem_rd) rq <= mem[mem_addr];
    for (int p = 0; p < 4; p++)
      if (mem_we[p]) mem[mem_addr][8*p +: 8] <= mem_wdata[8*p +: 8];
  end

  // bench model of one plane, written bit by bit
  function automatic logic [7:0] model(input logic [1:0] f, input logic [7:0] d,
      input logic [7:0] l, input logic [7:0] m);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) begin
      logic o;
      case (f)
        2'd0: o = d[b];
        2'd1: o = !(!d[b] || !l[b]);
        2'd2: o = !(!d[b] && !l[b]);
        default: o = (d[b] != l[b]);
      endcase
      r[b] = m[b] ? o : l[b];
    end
    return r;
  endfunction

  function automatic logic [7:0] pat(input int s, input int p);
    return 8'(((s * 91) + (p * 39) + 7) ^ 8'hA5);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d,
      input logic [1:0] f, input logic [7:0] m, input logic [3:0] en,
      input logic cp);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cfg_fn = f; cfg_mask = m;
    cfg_plane_en = en; cfg_copy = cp; cpu_wr = 1'b1;
    #1;
    check("R9 we", {28'd0, mem_we}, {28'd0, en});
    check("R9 addr", {28'd0, mem_addr}, {28'd0, a});
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [1:0] sel,
      input logic [7:0] exp_byte);
    @(negedge clk);
    cpu_addr = a; cfg_rd_plane = sel; cpu_rd = 1'b1;
    #1;
    check("R2 mem_rd", {31'd0, mem_rd}, 32'd1);
    @(negedge clk);
    cpu_rd = 1'b0;
    cfg_rd_plane = sel + 2'd1;  // later changes must not matter
    check("R2 early valid", {31'd0, cpu_rvalid}, 32'd0);
    @(negedge clk);
    check("R2 valid", {31'd0, cpu_rvalid}, 32'd1);
    check("R2 rdata", {24'd0, cpu_rdata}, {24'd0, exp_byte});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] lat [4];
    logic [31:0] expw;
    for (int i = 0; i < 16; i++) mem[i] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, latches zero seen through a copy write
    check("R1 rvalid", {31'd0, cpu_rvalid}, 32'd0);
    check("R1 we", {28'd0, mem_we}, 32'd0);
    do_write(4'd0, 8'h5A, 2'd3, 8'hFF, 4'hF, 1'b1);
    check("R1 latches zero", mem[0], 32'd0);

    for (int s = 0; s < 4; s++) begin
      // build a distinct per-plane pattern at address 1
      for (int p = 0; p < 4; p++)
        do_write(4'd1, pat(s, p), 2'd0, 8'hFF, 4'(1 << p), 1'b0);
      for (int p = 0; p < 4; p++) lat[p] = pat(s, p);
      // R2/R3: every plane readable; each read reloads all latches
      for (int p = 0; p < 4; p++) do_read(4'd1, 2'(p), lat[p]);
      for (int f = 0; f < 4; f++)
        for (int mi = 0; mi < 4; mi++)
          for (int di = 0; di < 4; di++) begin
            logic [7:0] m, d;
            m = (mi == 0) ? 8'h00 : (mi == 1) ? 8'hFF : (mi == 2) ? 8'h0F : 8'(8'hA5 ^ s);
            d = 8'((di * 77) + (s * 13) + 3);
            mem[2] = 32'h1234_5678;
            do_write(4'd2, d, 2'(f), m, 4'hF, 1'b0);
            for (int p = 0; p < 4; p++) expw[8*p +: 8] = model(2'(f), d, lat[p], m);
            check(mi == 0 ? "R5 zero mask" : "R4 function/R5 mask", mem[2], expw);
          end
      // R6 + R8: copy after many writes still gives the latched pattern
      mem[3] = 32'h0;
      do_write(4'd3, 8'h99, 2'd2, 8'h3C, 4'hF, 1'b1);
      check("R6 copy / R8 latch hold", mem[3], {lat[3], lat[2], lat[1], lat[0]});
    end

    // R7: every plane enable combination
    for (int en = 0; en < 16; en++) begin
      mem[4] = 32'h1122_3344;
      do_write(4'd4, 8'hC3, 2'd0, 8'hFF, 4'(en), 1'b0);
      for (int p = 0; p < 4; p++)
        expw[8*p +: 8] = en[p] ? 8'hC3 : 8'(32'h1122_3344 >> (8*p));
      check("R7 plane enable", mem[4], expw);
    end

    // R10: simultaneous read and write -> read only
    mem[5] = 32'hDEAD_BEEF;
    @(negedge clk);
    cpu_addr = 4'd5; cfg_rd_plane = 2'd3; cpu_wdata = 8'h00;
    cfg_fn = 2'd0; cfg_mask = 8'hFF; cfg_plane_en = 4'hF; cfg_copy = 1'b0;
    cpu_rd = 1'b1; cpu_wr = 1'b1;
    #1;
    check("R10 no we", {28'd0, mem_we}, 32'd0);
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    @(negedge clk);
    check("R10 mem intact", mem[5], 32'hDEAD_BEEF);
    check("R10 read data", {24'd0, cpu_rdata}, 32'h0000_00DE);
    do_write(4'd6, 8'h00, 2'd0, 8'h00, 4'hF, 1'b0);
    check("R3 latches from dual strobe", mem[6], 32'hDEAD_BEEF);

    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule